// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading two levels of translation tables held in memory. A requester presents a virtual address together with the access kind (read or write) and a 2-bit privilege level. The walker first fetches the directory entry and then the table entry that the directory entry points to. It checks the presence, write and user permissions, and answers with either the physical address or a fault.

A fault response carries a 4-bit error code. The block also keeps the faulting virtual address in a register that holds its value until the next fault.

The walker handles one translation at a time. It uses a single-outstanding memory read port: the address is held until the memory accepts it, and the data comes back later with its own valid strobe. The directory base is sampled when a request is accepted. Only its upper 20 bits are used.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1, `rsp_valid_o` is 0, `mem_rd_valid_o` is 0 and `fault_addr_o` is 0.
- R2: The first read of a walk uses the address {pdbr_i[31:12], vaddr[31:22], 2'b00}. Bits 11:0 of `pdbr_i` have no effect.
- R3: The second read uses {directory entry[31:12], vaddr[21:12], 2'b00}. It is issued only after the directory data has returned.
- R4: A successful walk responds with fault 0, error code 0 and physical address {table entry[31:12], vaddr[11:0]}.
- R5: A directory entry with bit 0 (present) clear ends the walk with a fault and error code bit 0 = 0. No table read is made.
- R6: A table entry with bit 0 clear gives a fault with error code bit 0 = 0.
- R7: In the error code, bit 0 is 1 when both entries were present and a permission check failed. Bit 1 is 1 when the access was a write, bit 2 is 1 when the privilege level was 3, and bit 3 is always 0.
- R8: Privilege level 3 counts as user. A user access faults unless bit 2 (user) is set in both entries. Levels 0, 1 and 2 ignore bit 2.
- R9: A user write faults unless bit 1 (writable) is set in both entries. A supervisor write to a read-only page succeeds.
- R10: On a fault, `fault_addr_o` takes the faulting virtual address in the same cycle as the response. Otherwise, including on a successful response, it keeps its value.
- R11: Only one translation is in flight. `req_ready_o` is low from acceptance until after the response. `rsp_valid_o` is a one-cycle pulse. A memory read request holds its address until it is accepted.
- R12: Entry bits 3 to 11 have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pdbr_i | input | 32 | Directory base; bits 31:12 used |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | 1 = write access |
| req_cpl_i | input | 2 | Privilege level, 3 = user |
| mem_rd_valid_o | output | 1 | Memory read request |
| mem_rd_ready_i | input | 1 | Memory accepts the read |
| mem_rd_addr_o | output | 32 | Entry address to read |
| mem_rd_rvalid_i | input | 1 | Read data valid |
| mem_rd_rdata_i | input | 32 | Read data (entry) |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_fault_o | output | 1 | Translation faulted |
| rsp_ecode_o | output | 4 | Fault error code |
| fault_addr_o | output | 32 | Last faulting virtual address |

## Verification
The hardest case to reach from the ports is a fault raised by the table level after a present directory entry, while the memory stalls its accept and delays its data. The fault-address register must then keep its old value through the successful walks that follow. The bench builds small directory and table images in a memory model. It varies the accept stall and the data latency from walk to walk. It mixes hand-placed permission corner cases with a pseudo-random sweep over populated and unpopulated entries, and compares the walker against the behavioural model on every clock.

// File: rtl/ptw_pkg.sv
// Shared constants and types for the page table walker.
// Assumes 4-byte entries and page-aligned tables.
package ptw_pkg;
    localparam int ENTRY_LOG2 = 2;
    localparam int FLAG_P     = 0;
    localparam int FLAG_W     = 1;
    localparam int FLAG_U     = 2;
    localparam int ECODE_W    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_RESP
    } walk_state_t;
endpackage

// File: rtl/ptw_perm_check.sv
// Combinational presence and permission check for one walk step.
// With final_i low, only the directory entry's present bit is judged.
// With final_i high, the table entry's present bit is judged, and then the
// user and write rights taken as the AND of both levels.
// Error code: [0] present-violation, [1] write, [2] user, [3] zero.
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic [2:0]         dir_flags_i,
    input  logic [2:0]         tbl_flags_i,
    input  logic               final_i,
    input  logic               is_write_i,
    input  logic               is_user_i,
    output logic               deny_o,
    output logic [ECODE_W-1:0] ecode_o
);
    logic not_present;
    logic eff_user;
    logic eff_write;
    logic prot_viol;

    // Decide presence and rights for the current step.
    always_comb begin
        eff_user  = dir_flags_i[FLAG_U] & tbl_flags_i[FLAG_U];
        eff_write = dir_flags_i[FLAG_W] & tbl_flags_i[FLAG_W];
        if (!final_i) begin
            not_present = ~dir_flags_i[FLAG_P];
            prot_viol   = 1'b0;
        end else begin
            not_present = ~tbl_flags_i[FLAG_P];
            prot_viol   = is_user_i & (~eff_user | (is_write_i & ~eff_write));
        end
        deny_o  = not_present | prot_viol;
        ecode_o = {1'b0, is_user_i, is_write_i, ~not_present};
    end
endmodule

// File: rtl/ptw_fault_addr.sv
// Holds the virtual address of the most recent faulting translation.
// Assumes load_i pulses for exactly one cycle per fault.
module ptw_fault_addr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] va_i,
    output logic [ADDR_W-1:0] fault_addr_o
);
    // Capture the faulting address, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      fault_addr_o <= '0;
        else if (load_i) fault_addr_o <= va_i;
    end
endmodule

// File: rtl/ptw_walk_ctrl.sv
// Sequencer of the two-level walk: accepts one request, issues the
// directory read, then the table read, and produces a one-cycle response.
// Assumes the memory returns exactly one data beat per accepted read.
module ptw_walk_ctrl
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  pdbr_i,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic [ADDR_W-1:0]  req_vaddr_i,
    input  logic               req_write_i,
    input  logic [1:0]         req_cpl_i,
    output logic               mem_rd_valid_o,
    input  logic               mem_rd_ready_i,
    output logic [ADDR_W-1:0]  mem_rd_addr_o,
    input  logic               mem_rd_rvalid_i,
    input  logic [ADDR_W-1:0]  mem_rd_rdata_i,
    output logic [2:0]         chk_dir_flags_o,
    output logic [2:0]         chk_tbl_flags_o,
    output logic               chk_final_o,
    output logic               chk_write_o,
    output logic               chk_user_o,
    input  logic               chk_deny_i,
    input  logic [ECODE_W-1:0] chk_ecode_i,
    output logic               fault_load_o,
    output logic [ADDR_W-1:0]  fault_va_o,
    output logic               rsp_valid_o,
    output logic [ADDR_W-1:0]  rsp_paddr_o,
    output logic               rsp_fault_o,
    output logic [ECODE_W-1:0] rsp_ecode_o
);
    localparam int IDX_W   = OFFS_W - ENTRY_LOG2;
    localparam int FRAME_W = ADDR_W - OFFS_W;
    localparam int DIR_W   = ADDR_W - OFFS_W - IDX_W;

    walk_state_t        state_q;
    logic [ADDR_W-1:0]  va_q;
    logic               wr_q;
    logic               user_q;
    logic [FRAME_W-1:0] dir_base_q;
    logic [ADDR_W-1:0]  pde_q;
    logic               step_done;

    logic [DIR_W-1:0]   dir_idx;
    logic [IDX_W-1:0]   tbl_idx;

    // Split the captured virtual address into its index fields.
    always_comb begin
        dir_idx = va_q[ADDR_W-1 -: DIR_W];
        tbl_idx = va_q[OFFS_W +: IDX_W];
    end

    // Drive the memory read request for the current level.
    always_comb begin
        mem_rd_valid_o = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
        if (state_q == ST_DIR_REQ)
            mem_rd_addr_o = {dir_base_q, dir_idx, {ENTRY_LOG2{1'b0}}};
        else
            mem_rd_addr_o = {pde_q[ADDR_W-1 -: FRAME_W], tbl_idx, {ENTRY_LOG2{1'b0}}};
    end

    // Route the returning entry to the permission checker.
    always_comb begin
        chk_final_o = (state_q == ST_TBL_WAIT);
        chk_write_o = wr_q;
        chk_user_o  = user_q;
        if (state_q == ST_TBL_WAIT) begin
            chk_dir_flags_o = pde_q[2:0];
            chk_tbl_flags_o = mem_rd_rdata_i[2:0];
        end else begin
            chk_dir_flags_o = mem_rd_rdata_i[2:0];
            chk_tbl_flags_o = 3'b000;
        end
    end

    // Detect the cycle in which the walk finishes.
    always_comb begin
        step_done = mem_rd_rvalid_i &&
                    ((state_q == ST_TBL_WAIT) ||
                     ((state_q == ST_DIR_WAIT) && chk_deny_i));
        fault_load_o = step_done && chk_deny_i;
        fault_va_o   = va_q;
        req_ready_o  = (state_q == ST_IDLE);
        rsp_valid_o  = (state_q == ST_RESP);
    end

    // Advance the walk state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     if (req_valid_i)     state_q <= ST_DIR_REQ;
                ST_DIR_REQ:  if (mem_rd_ready_i)  state_q <= ST_DIR_WAIT;
                ST_DIR_WAIT: if (mem_rd_rvalid_i) state_q <= chk_deny_i ? ST_RESP : ST_TBL_REQ;
                ST_TBL_REQ:  if (mem_rd_ready_i)  state_q <= ST_TBL_WAIT;
                ST_TBL_WAIT: if (mem_rd_rvalid_i) state_q <= ST_RESP;
                ST_RESP:                          state_q <= ST_IDLE;
                default:                          state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the request and the directory base on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q       <= '0;
            wr_q       <= 1'b0;
            user_q     <= 1'b0;
            dir_base_q <= '0;
        end else if (state_q == ST_IDLE && req_valid_i) begin
            va_q       <= req_vaddr_i;
            wr_q       <= req_write_i;
            user_q     <= (req_cpl_i == 2'd3);
            dir_base_q <= pdbr_i[ADDR_W-1 -: FRAME_W];
        end
    end

    // Keep the directory entry for the second lookup.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pde_q <= '0;
        else if (state_q == ST_DIR_WAIT && mem_rd_rvalid_i)
            pde_q <= mem_rd_rdata_i;
    end

    // Register the response fields as the walk completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_paddr_o <= '0;
            rsp_fault_o <= 1'b0;
            rsp_ecode_o <= '0;
        end else if (step_done) begin
            rsp_fault_o <= chk_deny_i;
            rsp_ecode_o <= chk_deny_i ? chk_ecode_i : '0;
            rsp_paddr_o <= chk_deny_i ? '0 :
                           {mem_rd_rdata_i[ADDR_W-1 -: FRAME_W], va_q[OFFS_W-1:0]};
        end
    end
endmodule

// File: rtl/pt_walker.sv
// Top of the two-level page table walker: joins the sequencer, the
// permission checker and the fault-address register.
// Assumes a single-outstanding memory read port.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  pdbr_i,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic [ADDR_W-1:0]  req_vaddr_i,
    input  logic               req_write_i,
    input  logic [1:0]         req_cpl_i,
    output logic               mem_rd_valid_o,
    input  logic               mem_rd_ready_i,
    output logic [ADDR_W-1:0]  mem_rd_addr_o,
    input  logic               mem_rd_rvalid_i,
    input  logic [ADDR_W-1:0]  mem_rd_rdata_i,
    output logic               rsp_valid_o,
    output logic [ADDR_W-1:0]  rsp_paddr_o,
    output logic               rsp_fault_o,
    output logic [ECODE_W-1:0] rsp_ecode_o,
    output logic [ADDR_W-1:0]  fault_addr_o
);
    logic [2:0]         dir_flags;
    logic [2:0]         tbl_flags;
    logic               chk_final;
    logic               chk_write;
    logic               chk_user;
    logic               chk_deny;
    logic [ECODE_W-1:0] chk_ecode;
    logic               fault_load;
    logic [ADDR_W-1:0]  fault_va;

    ptw_walk_ctrl #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .pdbr_i          (pdbr_i),
        .req_valid_i     (req_valid_i),
        .req_ready_o     (req_ready_o),
        .req_vaddr_i     (req_vaddr_i),
        .req_write_i     (req_write_i),
        .req_cpl_i       (req_cpl_i),
        .mem_rd_valid_o  (mem_rd_valid_o),
        .mem_rd_ready_i  (mem_rd_ready_i),
        .mem_rd_addr_o   (mem_rd_addr_o),
        .mem_rd_rvalid_i (mem_rd_rvalid_i),
        .mem_rd_rdata_i  (mem_rd_rdata_i),
        .chk_dir_flags_o (dir_flags),
        .chk_tbl_flags_o (tbl_flags),
        .chk_final_o     (chk_final),
        .chk_write_o     (chk_write),
        .chk_user_o      (chk_user),
        .chk_deny_i      (chk_deny),
        .chk_ecode_i     (chk_ecode),
        .fault_load_o    (fault_load),
        .fault_va_o      (fault_va),
        .rsp_valid_o     (rsp_valid_o),
        .rsp_paddr_o     (rsp_paddr_o),
        .rsp_fault_o     (rsp_fault_o),
        .rsp_ecode_o     (rsp_ecode_o)
    );

    ptw_perm_check u_perm (
        .dir_flags_i (dir_flags),
        .tbl_flags_i (tbl_flags),
        .final_i     (chk_final),
        .is_write_i  (chk_write),
        .is_user_i   (chk_user),
        .deny_o      (chk_deny),
        .ecode_o     (chk_ecode)
    );

    ptw_fault_addr #(.ADDR_W(ADDR_W)) u_faddr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (fault_load),
        .va_i         (fault_va),
        .fault_addr_o (fault_addr_o)
    );
endmodule

// File: rtl/pt_walker_chk.sv
// Protocol and response checker for pt_walker, attached by bind.
// Keeps its own copy of the accepted request to judge the response.
module pt_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] pdbr_i,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic [ADDR_W-1:0] req_vaddr_i,
    input logic              req_write_i,
    input logic [1:0]        req_cpl_i,
    input logic              mem_rd_valid_o,
    input logic              mem_rd_ready_i,
    input logic [ADDR_W-1:0] mem_rd_addr_o,
    input logic              rsp_valid_o,
    input logic [ADDR_W-1:0] rsp_paddr_o,
    input logic              rsp_fault_o,
    input logic [3:0]        rsp_ecode_o,
    input logic [ADDR_W-1:0] fault_addr_o
);
    localparam int IDX_W = OFFS_W - 2;
    localparam int DIR_W = ADDR_W - OFFS_W - IDX_W;

    logic [ADDR_W-1:0] va_seen;
    logic [ADDR_W-1:0] pdbr_seen;
    logic              wr_seen;
    logic              user_seen;
    logic              first_rd;

    // Record each accepted request and whether its first read is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_seen   <= '0;
            pdbr_seen <= '0;
            wr_seen   <= 1'b0;
            user_seen <= 1'b0;
            first_rd  <= 1'b0;
        end else if (req_valid_i && req_ready_o) begin
            va_seen   <= req_vaddr_i;
            pdbr_seen <= pdbr_i;
            wr_seen   <= req_write_i;
            user_seen <= (req_cpl_i == 2'd3);
            first_rd  <= 1'b1;
        end else if (mem_rd_valid_o && mem_rd_ready_i) begin
            first_rd  <= 1'b0;
        end
    end

    assert_dir_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid_o && first_rd |->
        mem_rd_addr_o == {pdbr_seen[ADDR_W-1:OFFS_W], va_seen[ADDR_W-1 -: DIR_W], 2'b00});

    assert_ok_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && !rsp_fault_o |->
        rsp_ecode_o == 4'd0 && rsp_paddr_o[OFFS_W-1:0] == va_seen[OFFS_W-1:0]);

    assert_code_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && rsp_fault_o |-> rsp_ecode_o[3:1] == {1'b0, user_seen, wr_seen});

    assert_fa_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && rsp_fault_o |-> fault_addr_o == va_seen);

    assert_fa_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid_o && rsp_fault_o) |-> $stable(fault_addr_o));

    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);

    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o || mem_rd_valid_o) |-> !req_ready_o);

    assert_memreq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid_o && !mem_rd_ready_i |=> mem_rd_valid_o && $stable(mem_rd_addr_o));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pdbr_i         (pdbr_i),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .req_vaddr_i    (req_vaddr_i),
    .req_write_i    (req_write_i),
    .req_cpl_i      (req_cpl_i),
    .mem_rd_valid_o (mem_rd_valid_o),
    .mem_rd_ready_i (mem_rd_ready_i),
    .mem_rd_addr_o  (mem_rd_addr_o),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_paddr_o    (rsp_paddr_o),
    .rsp_fault_o    (rsp_fault_o),
    .rsp_ecode_o    (rsp_ecode_o),
    .fault_addr_o   (fault_addr_o)
);

// File: tb/tb_pt_walker.sv
// Self-checking bench: behavioural memory and translation model,
// compared against the walker on every clock of every walk.
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pdbr_i = '0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [31:0] req_vaddr_i = '0;
    logic        req_write_i = 1'b0;
    logic [1:0]  req_cpl_i = '0;
    logic        mem_rd_valid_o;
    logic        mem_rd_ready_i = 1'b0;
    logic [31:0] mem_rd_addr_o;
    logic        mem_rd_rvalid_i = 1'b0;
    logic [31:0] mem_rd_rdata_i = '0;
    logic        rsp_valid_o;
    logic [31:0] rsp_paddr_o;
    logic        rsp_fault_o;
    logic [3:0]  rsp_ecode_o;
    logic [31:0] fault_addr_o;

    always #2 clk = ~clk;

    pt_walker dut (.*);

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] exp_rd_q [$];
    logic [31:0] model_fa = '0;
    int stall_set = 0;
    int lat_set = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    function automatic logic [31:0] rd(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] nxt(logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Memory responder: stalls the accept, returns data after a latency.
    initial begin
        bit          armed = 0;
        int          cnt = 0;
        int          stall_ctr = 0;
        logic [31:0] cap = '0;
        forever begin
            @(negedge clk);
            mem_rd_rvalid_i = 1'b0;
            if (armed) begin
                armed = 0;
                mem_rd_ready_i = 1'b0;
                if (exp_rd_q.size() == 0) begin
                    chk(0, "R5", "unexpected read", cap, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_rd_q.pop_front();
                    chk(cap == e, "R3", "read address", cap, e);
                end
                cnt = lat_set + 1;
            end
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rd_rvalid_i = 1'b1;
                    mem_rd_rdata_i  = rd(cap);
                end
            end else if (mem_rd_valid_o && !mem_rd_ready_i) begin
                if (stall_ctr < stall_set) stall_ctr++;
                else begin
                    stall_ctr = 0;
                    mem_rd_ready_i = 1'b1;
                    armed = 1;
                    cap = mem_rd_addr_o;
                end
            end
        end
    end

    // One translation: model, drive, per-clock compare, response compare.
    task automatic walk(logic [31:0] pdbr, logic [31:0] va, bit wr, logic [1:0] cpl, string rq);
        logic [31:0] pde_a, pte_a, pde, pte, epa;
        bit          efault, user, prot;
        logic [3:0]  eec;
        int          n;
        user = (cpl == 2'd3);
        efault = 0; eec = 4'd0; epa = 32'h0;
        pde_a = {pdbr[31:12], va[31:22], 2'b00};
        pde = rd(pde_a);
        exp_rd_q.push_back(pde_a);
        if (!pde[0]) begin
            efault = 1; eec = {1'b0, user, wr, 1'b0};
        end else begin
            pte_a = {pde[31:12], va[21:12], 2'b00};
            pte = rd(pte_a);
            exp_rd_q.push_back(pte_a);
            if (!pte[0]) begin
                efault = 1; eec = {1'b0, user, wr, 1'b0};
            end else begin
                prot = user && (!(pde[2] && pte[2]) || (wr && !(pde[1] && pte[1])));
                if (prot) begin
                    efault = 1; eec = {1'b0, user, wr, 1'b1};
                end else epa = {pte[31:12], va[11:0]};
            end
        end
        chk(req_ready_o == 1'b1, "R11", "ready when idle", {31'h0, req_ready_o}, 32'h1);
        pdbr_i = pdbr; req_vaddr_i = va; req_write_i = wr; req_cpl_i = cpl;
        req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        pdbr_i = 32'hFFFF_FFFF;
        n = 0;
        while (!rsp_valid_o && n < 200) begin
            chk(req_ready_o == 1'b0, "R11", "busy not ready", {31'h0, req_ready_o}, 32'h0);
            chk(fault_addr_o == model_fa, "R10", "fault addr held", fault_addr_o, model_fa);
            @(negedge clk);
            n++;
        end
        chk(rsp_valid_o == 1'b1, rq, "response arrived", {31'h0, rsp_valid_o}, 32'h1);
        chk(rsp_fault_o == efault, rq, "fault flag", {31'h0, rsp_fault_o}, {31'h0, efault});
        chk(rsp_ecode_o == eec, rq, "error code", {28'h0, rsp_ecode_o}, {28'h0, eec});
        if (!efault) chk(rsp_paddr_o == epa, rq, "physical address", rsp_paddr_o, epa);
        if (efault) model_fa = va;
        chk(fault_addr_o == model_fa, "R10", "fault addr at response", fault_addr_o, model_fa);
        chk(exp_rd_q.size() == 0, "R5", "all reads made", exp_rd_q.size(), 32'h0);
        exp_rd_q.delete();
        @(negedge clk);
        chk(rsp_valid_o == 1'b0, "R11", "response pulse", {31'h0, rsp_valid_o}, 32'h0);
        chk(req_ready_o == 1'b1, "R11", "ready after response", {31'h0, req_ready_o}, 32'h1);
        chk(fault_addr_o == model_fa, "R10", "fault addr after", fault_addr_o, model_fa);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // Directed cases followed by a pseudo-random sweep.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready_o == 1'b1, "R1", "reset ready", {31'h0, req_ready_o}, 32'h1);
        chk(rsp_valid_o == 1'b0, "R1", "reset rsp", {31'h0, rsp_valid_o}, 32'h0);
        chk(mem_rd_valid_o == 1'b0, "R1", "reset mem", {31'h0, mem_rd_valid_o}, 32'h0);
        chk(fault_addr_o == 32'h0, "R1", "reset fault addr", fault_addr_o, 32'h0);

        // Directory at 0x11000, table at 0x12000.
        mem[32'h0001_1000] = 32'h0001_2007;          // dir 0: P W U
        mem[32'h0001_2000] = 32'h000B_8007;          // va page 0x00000
        mem[32'h0001_2040] = 32'h0001_0FF7;          // page 0x10, junk bits 4-11
        mem[32'h0001_2044] = 32'h0003_3003;          // page 0x11: P W, supervisor
        mem[32'h0001_2048] = 32'h0004_4005;          // page 0x12: P U, read-only
        mem[32'h0001_204C] = 32'h0005_5006;          // page 0x13: not present
        mem[32'h0001_1004] = 32'h0001_3001;          // dir 1: P only
        mem[32'h0001_3000] = 32'h0006_6007;          // va 0x00400000
        mem[32'h0001_1008] = 32'h0001_4005;          // dir 2: P U, no W
        mem[32'h0001_4000] = 32'h0007_7007;          // va 0x00800000

        walk(32'h0001_1ABC, 32'h0000_0123, 0, 2'd0, "R2");   // low base bits ignored
        walk(32'h0001_1000, 32'h0001_0456, 0, 2'd3, "R12");  // extra entry bits
        walk(32'h0001_1000, 32'h0000_0FFC, 1, 2'd3, "R4");
        walk(32'h0001_1000, 32'h00C0_0010, 1, 2'd3, "R5");   // dir 3 absent: 0110
        walk(32'h0001_1000, 32'h0001_3777, 0, 2'd0, "R6");   // 0000
        walk(32'h0001_1000, 32'h0001_1008, 0, 2'd3, "R8");   // tbl U=0: 0101
        walk(32'h0001_1000, 32'h0040_0020, 0, 2'd3, "R8");   // dir U=0: 0101
        walk(32'h0001_1000, 32'h0001_1ABC, 0, 2'd1, "R8");   // supervisor ok
        walk(32'h0001_1000, 32'h0001_1ABC, 1, 2'd2, "R8");   // level 2 is supervisor
        walk(32'h0001_1000, 32'h0001_2004, 1, 2'd3, "R9");   // tbl W=0: 0111
        walk(32'h0001_1000, 32'h0080_0008, 1, 2'd3, "R9");   // dir W=0: 0111
        walk(32'h0001_1000, 32'h0001_2100, 1, 2'd0, "R9");   // supervisor write ok
        walk(32'h0001_1000, 32'h0001_2200, 0, 2'd3, "R7");   // user read ok
        walk(32'h0001_1000, 32'h0000_0333, 0, 2'd3, "R10");  // success keeps addr

        // Random images: dirs 0..3 at 0x30000, tables at 0x40000 + k*0x1000.
        for (int k = 0; k < 4; k++) begin
            lfsr = nxt(lfsr);
            mem[32'h0003_0000 + k * 4] = (32'h0004_0000 + k * 32'h1000) |
                                         {21'h0, lfsr[10:3], 3'h0} | {29'h0, lfsr[2:0]};
            for (int j = 0; j < 8; j++) begin
                lfsr = nxt(lfsr);
                mem[32'h0004_0000 + k * 32'h1000 + j * 4] = {lfsr[31:12], 12'h0} | {20'h0, lfsr[11:0]};
            end
        end
        for (int t = 0; t < 40; t++) begin
            logic [31:0] va;
            lfsr = nxt(lfsr);
            stall_set = lfsr[1:0];
            lat_set = lfsr[3:2];
            va = {7'h0, lfsr[6:4], 7'h0, lfsr[9:7], lfsr[21:10]};
            walk(32'h0003_0000, va, lfsr[22], lfsr[24:23], "R7");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule